// File: doc/BRIEF.md
# Bus Endianness Lane Swapper

This block sits between a 16-bit big-endian processor bus and a little-endian shared memory. One physical memory is seen by the processor through two address windows of equal size. In the swapped window, data-space cycles have their byte lanes exchanged and word address bit A1 inverted. As a result, a 32-bit value written as two consecutive 16-bit cycles lands in memory in little-endian byte order. In the plain window every cycle passes straight through, which keeps byte streams and bit-field registers intact.

The decision is made once per bus cycle. The function code and address are captured at the clock edge that first sees address strobe asserted, and that decision holds until the strobe is released. Only the two data-space function codes qualify for swapping. Program fetches, CPU-space cycles and undefined codes are never altered, so code keeps executing from either window. The block also returns the data-acknowledge to the processor once the memory reports ready, and it controls the enable of the processor-side data drivers.

Top module: `endian_lane_bridge`

## Requirements
- R1: After reset and before any bus cycle, `cpu_dtack_n` is 1 and `mem_cs` and `cpu_drive_en` are 0.
- R2: In a swapped cycle, the two data bytes are exchanged in both directions. On a write, `mem_wdata` = {cpu_data[7:0], cpu_data[15:8]}. On a read, `cpu_data` = {mem_rdata[7:0], mem_rdata[15:8]}. A swapped cycle is one whose address lies in the swapped window and whose `cpu_fc` is 3'b001 (user data) or 3'b101 (supervisor data).
- R3: In a swapped cycle, `mem_addr` equals the low WIN_W bits of `cpu_addr` with bit 0 (bus line A1) inverted.
- R4: In a swapped cycle, the strobes are crossed: `mem_lb_n` follows `cpu_uds_n` and `mem_ub_n` follows `cpu_lds_n`. A single-strobe byte cycle therefore lands on the opposite lane.
- R5: In the swapped window, any code other than 3'b001 and 3'b101 passes through unchanged: address, strobes and data. This covers 3'b010 and 3'b110 (program), 3'b111 (CPU space) and the remaining codes.
- R6: In the plain window, every code passes through unchanged, and `mem_addr` equals the low WIN_W bits of `cpu_addr`.
- R7: Address, function code and strobe direction are captured at the first clock edge that sees `cpu_as_n` low. Changes to `cpu_addr` or `cpu_fc` later in the same cycle have no effect on the memory outputs or on the read data.
- R8: For an address in either window, `cpu_dtack_n` falls at the first clock edge at which `mem_ready` is sampled high during the cycle. It rises again at the first clock edge after `cpu_as_n` returns high, and `mem_cs` drops at that same edge.
- R9: For an address outside both windows, `mem_cs` stays 0 and `cpu_dtack_n` stays 1 for the whole cycle.
- R10: `cpu_drive_en` is 1 only while `cpu_as_n` is low, the captured cycle is a read (`cpu_rw` = 1) and the address fell in a window. It drops without waiting for a clock edge when `cpu_as_n` rises. `cpu_data` is driven by the block only while `cpu_drive_en` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_addr | input | AW | Processor word address, bit 0 is line A1 |
| cpu_fc | input | 3 | Function code of the current cycle |
| cpu_as_n | input | 1 | Address strobe, active low |
| cpu_uds_n | input | 1 | Upper (even) byte strobe, active low |
| cpu_lds_n | input | 1 | Lower (odd) byte strobe, active low |
| cpu_rw | input | 1 | 1 = read, 0 = write |
| cpu_data | inout | 16 | Processor data bus |
| cpu_dtack_n | output | 1 | Data acknowledge to the processor, active low |
| cpu_drive_en | output | 1 | Enable of the processor-side data drivers |
| mem_cs | output | 1 | Memory select for a decoded cycle |
| mem_we | output | 1 | Memory write enable |
| mem_ub_n | output | 1 | Memory upper lane strobe, active low |
| mem_lb_n | output | 1 | Memory lower lane strobe, active low |
| mem_addr | output | WIN_W | Word offset into the shared memory |
| mem_wdata | output | 16 | Write data to memory |
| mem_rdata | input | 16 | Read data from memory |
| mem_ready | input | 1 | Memory has completed the access |

## Verification
The assertions rely on the processor presenting valid address, function code, strobes and direction in the cycle in which address strobe falls. They also rely on address strobe being high for at least one clock edge between two bus cycles. The properties that compare `mem_addr` with the address sampled one edge earlier rely on the address being stable at the capture edge. The bench applies every bus cycle in this way. It sets all inputs at a falling clock edge together with the strobe, and it perturbs address and function code only after the capture edge, which is how it exercises the latching. Memory ready is raised only after the first output checks and is lowered again with the strobe.

// File: rtl/elb_pkg.sv
// Shared definitions for the endianness lane swapper.
// Assumes a 16-bit data bus made of two byte lanes.
package elb_pkg;

    localparam int unsigned LANES  = 2;
    localparam int unsigned BUS_W  = 8 * LANES;

    // Function-code values that classify a bus cycle.
    typedef enum logic [2:0] {
        FC_USER_DATA = 3'b001,
        FC_USER_PROG = 3'b010,
        FC_SUP_DATA  = 3'b101,
        FC_SUP_PROG  = 3'b110,
        FC_CPU_SPACE = 3'b111
    } fc_code_e;

    // Per-cycle routing decision, captured at address strobe.
    typedef struct packed {
        logic hit;    // address falls in either window
        logic swap;   // lanes exchanged and A1 inverted
        logic rd;     // cycle is a read
        logic ub_n;   // memory upper lane strobe
        logic lb_n;   // memory lower lane strobe
    } route_t;

    // True for the two function codes that may be byte-swapped.
    function automatic logic is_data_space(input logic [2:0] fc);
        return (fc == FC_USER_DATA) || (fc == FC_SUP_DATA);
    endfunction

endpackage

// File: rtl/elb_decode.sv
// Window decode and swap decision for one bus cycle.
// Purely combinational. Assumes both window bases are aligned to
// 2**WIN_W words and that WIN_W < AW.
module elb_decode #(
    parameter int unsigned AW         = 23,
    parameter int unsigned WIN_W      = 16,
    parameter int unsigned SWAP_BASE  = 'h40000,
    parameter int unsigned PLAIN_BASE = 'h50000
) (
    input  logic [AW-1:0]     addr,
    input  logic [2:0]        fc,
    input  logic              uds_n,
    input  logic              lds_n,
    input  logic              rw,
    output elb_pkg::route_t   route,
    output logic [WIN_W-1:0]  ofs
);
    import elb_pkg::*;

    localparam int unsigned     TAG_W     = AW - WIN_W;
    localparam logic [TAG_W-1:0] SWAP_TAG  = TAG_W'(SWAP_BASE >> WIN_W);
    localparam logic [TAG_W-1:0] PLAIN_TAG = TAG_W'(PLAIN_BASE >> WIN_W);

    logic in_swap;
    logic in_plain;
    logic do_swap;

    // Compare the upper address bits with each window tag.
    always_comb begin
        in_swap  = (addr[AW-1:WIN_W] == SWAP_TAG);
        in_plain = (addr[AW-1:WIN_W] == PLAIN_TAG);
    end

    // Only data-space cycles in the swapped window are reordered.
    always_comb begin
        do_swap = in_swap && is_data_space(fc);
    end

    // Build the memory offset and the crossed or straight strobes.
    always_comb begin
        ofs        = addr[WIN_W-1:0] ^ {{(WIN_W-1){1'b0}}, do_swap};
        route.hit  = in_swap || in_plain;
        route.swap = do_swap;
        route.rd   = rw;
        route.ub_n = do_swap ? lds_n : uds_n;
        route.lb_n = do_swap ? uds_n : lds_n;
    end

endmodule

// File: rtl/elb_lane_mux.sv
// Byte-lane reorder for one direction of the data path.
// With swap set, lane i of the output takes lane LANES-1-i of the input.
module elb_lane_mux #(
    parameter int unsigned LANES = 2
) (
    input  logic                 swap,
    input  logic [8*LANES-1:0]   din,
    output logic [8*LANES-1:0]   dout
);
    genvar i;
    generate
        for (i = 0; i < LANES; i++) begin : g_lane
            // Select straight or mirrored source lane.
            always_comb begin
                dout[8*i +: 8] = swap ? din[8*(LANES-1-i) +: 8] : din[8*i +: 8];
            end
        end
    endgenerate

endmodule

// File: rtl/elb_cycle_ctl.sv
// Bus-cycle sequencer. Captures the routing decision at the first edge
// that sees address strobe low, holds it for the cycle, and produces
// memory select, acknowledge and read-driver enable.
// Assumes address strobe is high for at least one edge between cycles.
module elb_cycle_ctl #(
    parameter int unsigned WIN_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              as_n,
    input  elb_pkg::route_t   route_in,
    input  logic [WIN_W-1:0]  ofs_in,
    input  logic              mem_ready,
    output logic              active,
    output elb_pkg::route_t   route_q,
    output logic [WIN_W-1:0]  ofs_q,
    output logic              dtack_q,
    output logic              drive_en
);
    import elb_pkg::*;

    // Cycle state: capture on strobe entry, acknowledge on ready, clear on exit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active  <= 1'b0;
            route_q <= '0;
            ofs_q   <= '0;
            dtack_q <= 1'b0;
        end else if (as_n) begin
            active  <= 1'b0;
            dtack_q <= 1'b0;
        end else if (!active) begin
            active  <= 1'b1;
            route_q <= route_in;
            ofs_q   <= ofs_in;
        end else if (route_q.hit && mem_ready) begin
            dtack_q <= 1'b1;
        end
    end

    // Drivers follow the live strobe so they release without a clock edge.
    always_comb begin
        drive_en = active && route_q.hit && route_q.rd && !as_n;
    end

endmodule

// File: rtl/endian_lane_bridge.sv
// Top of the endianness lane swapper. Maps a big-endian 16-bit processor
// bus onto a little-endian shared memory seen through a swapped and a
// plain window. Assumes address, function code, strobes and direction
// are valid when address strobe falls.
module endian_lane_bridge #(
    parameter int unsigned AW         = 23,
    parameter int unsigned WIN_W      = 16,
    parameter int unsigned SWAP_BASE  = 'h40000,
    parameter int unsigned PLAIN_BASE = 'h50000
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [AW-1:0]              cpu_addr,
    input  logic [2:0]                 cpu_fc,
    input  logic                       cpu_as_n,
    input  logic                       cpu_uds_n,
    input  logic                       cpu_lds_n,
    input  logic                       cpu_rw,
    inout  wire  [elb_pkg::BUS_W-1:0]  cpu_data,
    output logic                       cpu_dtack_n,
    output logic                       cpu_drive_en,
    output logic                       mem_cs,
    output logic                       mem_we,
    output logic                       mem_ub_n,
    output logic                       mem_lb_n,
    output logic [WIN_W-1:0]           mem_addr,
    output logic [elb_pkg::BUS_W-1:0]  mem_wdata,
    input  logic [elb_pkg::BUS_W-1:0]  mem_rdata,
    input  logic                       mem_ready
);
    import elb_pkg::*;

    route_t             route_d;
    route_t             route_q;
    logic [WIN_W-1:0]   ofs_d;
    logic [WIN_W-1:0]   ofs_q;
    logic               active;
    logic               dtack_q;
    logic [BUS_W-1:0]   rd_swapped;

    elb_decode #(
        .AW         (AW),
        .WIN_W      (WIN_W),
        .SWAP_BASE  (SWAP_BASE),
        .PLAIN_BASE (PLAIN_BASE)
    ) u_decode (
        .addr  (cpu_addr),
        .fc    (cpu_fc),
        .uds_n (cpu_uds_n),
        .lds_n (cpu_lds_n),
        .rw    (cpu_rw),
        .route (route_d),
        .ofs   (ofs_d)
    );

    elb_cycle_ctl #(
        .WIN_W (WIN_W)
    ) u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .as_n      (cpu_as_n),
        .route_in  (route_d),
        .ofs_in    (ofs_d),
        .mem_ready (mem_ready),
        .active    (active),
        .route_q   (route_q),
        .ofs_q     (ofs_q),
        .dtack_q   (dtack_q),
        .drive_en  (cpu_drive_en)
    );

    elb_lane_mux #(
        .LANES (LANES)
    ) u_wr_mux (
        .swap (route_q.swap),
        .din  (cpu_data),
        .dout (mem_wdata)
    );

    elb_lane_mux #(
        .LANES (LANES)
    ) u_rd_mux (
        .swap (route_q.swap),
        .din  (mem_rdata),
        .dout (rd_swapped)
    );

    // Memory-side controls are gated by a decoded, active cycle.
    always_comb begin
        mem_cs      = active && route_q.hit;
        mem_we      = mem_cs && !route_q.rd;
        mem_ub_n    = !(mem_cs && !route_q.ub_n);
        mem_lb_n    = !(mem_cs && !route_q.lb_n);
        mem_addr    = ofs_q;
        cpu_dtack_n = !dtack_q;
    end

    // Read data reaches the processor bus only through the enabled drivers.
    assign cpu_data = cpu_drive_en ? rd_swapped : {BUS_W{1'bz}};

endmodule

// File: rtl/elb_checker.sv
// Property checker for endian_lane_bridge, attached by bind.
// Assumes inputs are stable at the edge that captures a cycle.
module elb_checker #(
    parameter int unsigned AW         = 23,
    parameter int unsigned WIN_W      = 16,
    parameter int unsigned SWAP_BASE  = 'h40000,
    parameter int unsigned PLAIN_BASE = 'h50000
) (
    input logic              clk,
    input logic              rst_n,
    input logic [AW-1:0]     cpu_addr,
    input logic [2:0]        cpu_fc,
    input logic              cpu_as_n,
    input logic              cpu_dtack_n,
    input logic              cpu_drive_en,
    input logic              mem_cs,
    input logic              mem_we,
    input logic              mem_ub_n,
    input logic              mem_lb_n,
    input logic [WIN_W-1:0]  mem_addr,
    input logic              mem_ready
);
    localparam int unsigned      TAG_W     = AW - WIN_W;
    localparam logic [TAG_W-1:0] SWAP_TAG  = TAG_W'(SWAP_BASE >> WIN_W);
    localparam logic [TAG_W-1:0] PLAIN_TAG = TAG_W'(PLAIN_BASE >> WIN_W);

    logic in_swap;
    logic in_plain;
    logic data_fc;

    // Port-level classification of the present address and code.
    always_comb begin
        in_swap  = (cpu_addr[AW-1:WIN_W] == SWAP_TAG);
        in_plain = (cpu_addr[AW-1:WIN_W] == PLAIN_TAG);
        data_fc  = (cpu_fc == 3'b001) || (cpu_fc == 3'b101);
    end

    a_r3_swap_inverts_a1: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(mem_cs) && $past(in_swap && data_fc))
        |-> mem_addr == ($past(cpu_addr[WIN_W-1:0]) ^ {{(WIN_W-1){1'b0}}, 1'b1}));

    a_r5_program_passes: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(mem_cs) && $past(in_swap && !data_fc))
        |-> mem_addr == $past(cpu_addr[WIN_W-1:0]));

    a_r6_plain_passes: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(mem_cs) && $past(in_plain))
        |-> mem_addr == $past(cpu_addr[WIN_W-1:0]));

    a_r7_held_in_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_cs && $past(mem_cs))
        |-> ($stable(mem_addr) && $stable(mem_ub_n) && $stable(mem_lb_n) && $stable(mem_we)));

    a_r8_dtack_after_ready: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cpu_dtack_n) |-> $past(mem_ready) && $past(mem_cs));

    a_r9_dtack_needs_select: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_dtack_n |-> mem_cs);

    a_r10_drive_only_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_drive_en |-> (!cpu_as_n && mem_cs && !mem_we));

endmodule

bind endian_lane_bridge elb_checker #(
    .AW         (AW),
    .WIN_W      (WIN_W),
    .SWAP_BASE  (SWAP_BASE),
    .PLAIN_BASE (PLAIN_BASE)
) u_elb_checker (.*);

// File: tb/endian_lane_bridge_bench.sv
`timescale 1ns/1ps
// Sweeps every address, function code, strobe pattern and direction of a
// small configuration and compares the outputs with values computed here.
module endian_lane_bridge_bench;

    localparam int unsigned AW    = 8;
    localparam int unsigned WIN_W = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [AW-1:0] cpu_addr = '0;
    logic [2:0]  cpu_fc = '0;
    logic        cpu_as_n = 1'b1;
    logic        cpu_uds_n = 1'b1;
    logic        cpu_lds_n = 1'b1;
    logic        cpu_rw = 1'b1;
    wire  [15:0] cpu_data;
    logic        cpu_dtack_n;
    logic        cpu_drive_en;
    logic        mem_cs;
    logic        mem_we;
    logic        mem_ub_n;
    logic        mem_lb_n;
    logic [WIN_W-1:0] mem_addr;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata = '0;
    logic        mem_ready = 1'b0;

    logic        tb_oe = 1'b0;
    logic [15:0] tb_d = '0;
    assign cpu_data = tb_oe ? tb_d : 16'bz;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    endian_lane_bridge #(
        .AW (AW), .WIN_W (WIN_W), .SWAP_BASE ('h30), .PLAIN_BASE ('h50)
    ) u_endian_lane_bridge (
        .clk (clk), .rst_n (rst_n),
        .cpu_addr (cpu_addr), .cpu_fc (cpu_fc), .cpu_as_n (cpu_as_n),
        .cpu_uds_n (cpu_uds_n), .cpu_lds_n (cpu_lds_n), .cpu_rw (cpu_rw),
        .cpu_data (cpu_data), .cpu_dtack_n (cpu_dtack_n),
        .cpu_drive_en (cpu_drive_en), .mem_cs (mem_cs), .mem_we (mem_we),
        .mem_ub_n (mem_ub_n), .mem_lb_n (mem_lb_n), .mem_addr (mem_addr),
        .mem_wdata (mem_wdata), .mem_rdata (mem_rdata), .mem_ready (mem_ready)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // One complete bus cycle with checks at each phase.
    task automatic run_cycle(input int a, input int fc, input int sp, input bit rd);
        bit in_sw  = ((a >> WIN_W) == 3);
        bit in_pl  = ((a >> WIN_W) == 5);
        bit hit    = in_sw || in_pl;
        bit sw     = in_sw && (fc == 1 || fc == 5);
        bit uds_n  = (sp == 2);
        bit lds_n  = (sp == 1);
        logic [15:0] wd  = 16'((a * 16'h0101) ^ (fc * 16'h1357) ^ (sp * 16'h0F0F));
        logic [15:0] rdm = ~wd ^ 16'h00F0;
        logic [3:0]  eofs = 4'(a[3:0] ^ {3'b000, sw});
        logic [15:0] ewd = sw ? {wd[7:0], wd[15:8]} : wd;
        logic [15:0] erd = sw ? {rdm[7:0], rdm[15:8]} : rdm;
        bit eub_n = sw ? lds_n : uds_n;
        bit elb_n = sw ? uds_n : lds_n;
        string areq = sw ? "R3" : (in_pl ? "R6" : "R5");
        string lreq = sw ? "R4" : (in_pl ? "R6" : "R5");

        @(negedge clk);
        cpu_addr  = AW'(a);
        cpu_fc    = 3'(fc);
        cpu_uds_n = uds_n;
        cpu_lds_n = lds_n;
        cpu_rw    = rd;
        cpu_as_n  = 1'b0;
        tb_oe     = !rd;
        tb_d      = wd;
        mem_rdata = rdm;
        mem_ready = 1'b0;

        @(negedge clk);  // one edge after strobe: cycle captured
        chk("R9 mem_cs", 32'(mem_cs), 32'(hit));
        chk("R8 dtack before ready", 32'(cpu_dtack_n), 1);
        if (hit) begin
            chk(areq, 32'(mem_addr), 32'(eofs));
            chk(lreq, 32'({mem_ub_n, mem_lb_n}), 32'({eub_n, elb_n}));
            chk("R2 mem_we", 32'(mem_we), 32'(!rd));
            if (!rd) chk(sw ? "R2 write lanes" : "R5/R6 write straight", 32'(mem_wdata), 32'(ewd));
            chk("R10 drive_en", 32'(cpu_drive_en), 32'(rd));
            if (rd) chk(sw ? "R2 read lanes" : "R5/R6 read straight", 32'(cpu_data), 32'(erd));
        end else begin
            chk("R10 drive_en outside", 32'(cpu_drive_en), 0);
        end
        cpu_addr = cpu_addr ^ 8'hFF;
        cpu_fc   = cpu_fc ^ 3'b111;

        @(negedge clk);  // perturbed inputs must not matter
        chk("R7 mem_cs held", 32'(mem_cs), 32'(hit));
        if (hit) begin
            chk("R7 addr held", 32'(mem_addr), 32'(eofs));
            chk("R7 strobes held", 32'({mem_ub_n, mem_lb_n}), 32'({eub_n, elb_n}));
            if (rd) chk("R7 read data held", 32'(cpu_data), 32'(erd));
            if (!rd) chk("R7 write data held", 32'(mem_wdata), 32'(ewd));
        end
        mem_ready = 1'b1;

        @(negedge clk);  // ready sampled at the edge just passed
        chk(hit ? "R8 dtack after ready" : "R9 no dtack", 32'(cpu_dtack_n), 32'(!hit));

        cpu_as_n  = 1'b1;
        cpu_uds_n = 1'b1;
        cpu_lds_n = 1'b1;
        tb_oe     = 1'b0;
        #1;
        chk("R10 drive drops with strobe", 32'(cpu_drive_en), 0);
        mem_ready = 1'b0;

        @(negedge clk);
        chk("R8 dtack released", 32'(cpu_dtack_n), 1);
        chk("R8 select released", 32'(mem_cs), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 dtack idle", 32'(cpu_dtack_n), 1);
        chk("R1 mem_cs idle", 32'(mem_cs), 0);
        chk("R1 drive idle", 32'(cpu_drive_en), 0);
        for (int a = 0; a < 256; a++)
            for (int fc = 0; fc < 8; fc++)
                for (int sp = 0; sp < 3; sp++)
                    for (int rd = 0; rd < 2; rd++)
                        run_cycle(a, fc, sp, rd[0]);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

endmodule